// File: doc/BRIEF.md
# Multiplexed Pixel Input Deinterleaver

This block sits behind a narrow digital video input bus and rebuilds whole pixels from it. A 3-bit format select picks one of several packings. In three RGB packings each pixel arrives as two half-words on consecutive clock cycles, and the block joins them. In two luma/chroma packings a byte-serial 4:2:2 stream arrives, and each chroma pair is attached to the two luma samples that share it. One of the luma/chroma packings takes its line and frame timing from the sync pins. The other takes it from timing codes embedded in the byte stream.

Each assembled pixel leaves on a registered output with a one-cycle valid strobe. The three 8-bit channels carry red, green and blue in RGB packings, and Y, Cb and Cr in luma/chroma packings. The outputs also carry active-high horizontal sync, vertical sync and a field flag. The sync pins have programmable polarity. The format select is taken only during vertical blanking, so a frame is never decoded in two formats.

Top module: `pxd_deinterleave`

## Requirements
- R1: While rst_n is low and in the first cycle after it, pix_valid_o, hs_o, vs_o, field_o and ycc_o are 0.
- R2: Format 0 (5-6-5): first half bits [4:0] are blue and [7:5] are green[2:0]; second half bits [2:0] are green[5:3] and [7:3] are red. Each channel is widened to 8 bits with zeros in the low bits.
- R3: Format 1 (5-5-5): first half bits [4:0] are blue and [7:5] are green[2:0]; second half bits [1:0] are green[4:3] and [6:2] are red. Second-half bit 7 has no effect. Channels are zero-filled to 8 bits.
- R4: Format 2 (8-8-8 over two 12-bit halves): first half bits [7:0] are blue and [11:8] are green[3:0]; second half bits [3:0] are green[7:4] and [11:4] are red.
- R5: In RGB formats, pix_valid_o rises for one cycle in the cycle after the second half is sampled. Pairing restarts during horizontal or vertical blanking, so the first word after blanking is always a first half.
- R6: With a format other than 4, hs_o is 1 in the cycle after hs_i equals hpol_i and 0 otherwise. vs_o follows vs_i and vpol_i in the same way. While either sync is active, no pixel is produced.
- R7: fmt_i is adopted only in a cycle of vertical blanking. A change at any other time has no effect on decoding.
- R8: Format 3 (byte-serial on din_i[7:0], order Cb, Y0, Cr, Y1): after Cr a pixel (Y0, Cb, Cr) is output, and after Y1 a pixel (Y1, Cb, Cr) is output. Channel order is c0=Y, c1=Cb, c2=Cr, and ycc_o is 1.
- R9: Format 4 decodes the byte stream as in R8 but ignores the sync pins. The bytes FF, 00, 00 followed by a flag byte set field, vertical blank and horizontal blank from flag bits 6, 5 and 4. These appear on field_o, vs_o and hs_o in the cycle after the flag byte.
- R10: In format 4, a byte FF and the rest of a timing-code sequence never produce a pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din_i | input | 12 | Multiplexed input word |
| hs_i | input | 1 | Horizontal sync pin |
| vs_i | input | 1 | Vertical sync pin |
| hpol_i | input | 1 | Level of hs_i that means active |
| vpol_i | input | 1 | Level of vs_i that means active |
| fmt_i | input | 3 | Format select (0..4; 5..7 decode as 0) |
| pix_valid_o | output | 1 | Pixel strobe |
| c0_o | output | 8 | Red or Y |
| c1_o | output | 8 | Green or Cb |
| c2_o | output | 8 | Blue or Cr |
| ycc_o | output | 1 | Channels hold Y/Cb/Cr |
| hs_o | output | 1 | Horizontal sync, active high |
| vs_o | output | 1 | Vertical sync, active high |
| field_o | output | 1 | Field flag from embedded codes |

## Verification
The hardest situation to reach is embedded-timing decoding while the sync pins contradict the stream. To get there, the stimulus first moves the format to 4 under a vertical blank. It then holds hs_i at its active level throughout, and sends a blanking code, a start-of-active code, four data bytes and an end code. The hs_o output and the pixels must then follow only the codes. Format changes outside blanking, and a horizontal sync that cuts a pixel pair in half, are both driven on purpose. This shows that neither one leaves a stale first half or a wrong format behind.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
    localparam int CH_W  = 8;
    localparam int BUS_W = CH_W + CH_W / 2;
    localparam int FMT_W = 3;
    localparam logic [CH_W-1:0] CODE_LEAD = '1;
    localparam logic [CH_W-1:0] CODE_ZERO = '0;
    localparam int FLG_F = 6;
    localparam int FLG_V = 5;
    localparam int FLG_H = 4;

    typedef enum logic [FMT_W-1:0] {
        FMT_RGB565  = 3'd0,
        FMT_RGB555  = 3'd1,
        FMT_RGB888  = 3'd2,
        FMT_YCC_PIN = 3'd3,
        FMT_YCC_EMB = 3'd4
    } fmt_e;

    typedef struct packed {
        logic [CH_W-1:0] c0;
        logic [CH_W-1:0] c1;
        logic [CH_W-1:0] c2;
    } pix_t;

    function automatic fmt_e fmt_decode(input logic [FMT_W-1:0] v);
        if (v <= 3'd4) return fmt_e'(v);
        return FMT_RGB565;
    endfunction
endpackage

// File: rtl/pxd_rgb_unpack.sv
module pxd_rgb_unpack
    import pxd_pkg::*;
(
    input  fmt_e             mode_i,
    input  logic [BUS_W-1:0] first_i,
    input  logic [BUS_W-1:0] second_i,
    output pix_t             pix_o
);
    always_comb begin
        pix_o = '0;
        case (mode_i)
            FMT_RGB555: begin
                pix_o.c0 = {second_i[6:2], 3'b000};
                pix_o.c1 = {second_i[1:0], first_i[7:5], 3'b000};
                pix_o.c2 = {first_i[4:0], 3'b000};
            end
            FMT_RGB888: begin
                pix_o.c0 = second_i[11:4];
                pix_o.c1 = {second_i[3:0], first_i[11:8]};
                pix_o.c2 = first_i[7:0];
            end
            default: begin
                pix_o.c0 = {second_i[7:3], 3'b000};
                pix_o.c1 = {second_i[2:0], first_i[7:5], 2'b00};
                pix_o.c2 = {first_i[4:0], 3'b000};
            end
        endcase
    end
endmodule

// File: rtl/pxd_timecode.sv
module pxd_timecode
    import pxd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [CH_W-1:0] byte_i,
    output logic            strip_o,
    output logic            flag_o
);
    typedef enum logic [1:0] {TC_IDLE, TC_Z1, TC_Z2, TC_FLG} tc_e;

    tc_e st_d, st_q;

    always_comb begin
        st_d    = st_q;
        strip_o = 1'b0;
        flag_o  = 1'b0;
        if (!en_i) begin
            st_d = TC_IDLE;
        end else begin
            case (st_q)
                TC_IDLE: begin
                    if (byte_i == CODE_LEAD) begin
                        strip_o = 1'b1;
                        st_d    = TC_Z1;
                    end
                end
                TC_Z1, TC_Z2: begin
                    strip_o = 1'b1;
                    if (byte_i == CODE_ZERO)
                        st_d = (st_q == TC_Z1) ? TC_Z2 : TC_FLG;
                    else if (byte_i == CODE_LEAD)
                        st_d = TC_Z1;
                    else
                        st_d = TC_IDLE;
                end
                default: begin
                    strip_o = 1'b1;
                    flag_o  = 1'b1;
                    st_d    = TC_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TC_IDLE;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pxd_deinterleave.sv
module pxd_deinterleave
    import pxd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] din_i,
    input  logic             hs_i,
    input  logic             vs_i,
    input  logic             hpol_i,
    input  logic             vpol_i,
    input  logic [FMT_W-1:0] fmt_i,
    output logic             pix_valid_o,
    output logic [CH_W-1:0]  c0_o,
    output logic [CH_W-1:0]  c1_o,
    output logic [CH_W-1:0]  c2_o,
    output logic             ycc_o,
    output logic             hs_o,
    output logic             vs_o,
    output logic             field_o
);
    typedef struct packed {
        fmt_e             mode;
        logic [1:0]       phase;
        logic [BUS_W-1:0] first;
        logic [CH_W-1:0]  cb;
        logic [CH_W-1:0]  y0;
        logic [CH_W-1:0]  cr;
        logic             eh;
        logic             ev;
        logic             ef;
        logic             valid;
        pix_t             pix;
        logic             ycc;
        logic             hs;
        logic             vs;
        logic             fld;
    } st_t;

    localparam st_t ST_RESET = '{
        mode: FMT_RGB565, phase: '0, first: '0, cb: '0, y0: '0, cr: '0,
        eh: 1'b1, ev: 1'b1, ef: 1'b0, valid: 1'b0, pix: '0,
        ycc: 1'b0, hs: 1'b0, vs: 1'b0, fld: 1'b0
    };

    st_t st_d, st_q;

    logic            hs_act, vs_act, emb, ycc_m, blank, vblank;
    logic            strip, flag;
    logic [CH_W-1:0] byte_w;
    logic [FMT_W-1:0] cur_mode;
    pix_t            rgb_pix;

    assign byte_w   = din_i[CH_W-1:0];
    assign hs_act   = (hs_i == hpol_i);
    assign vs_act   = (vs_i == vpol_i);
    assign emb      = (st_q.mode == FMT_YCC_EMB);
    assign ycc_m    = emb || (st_q.mode == FMT_YCC_PIN);
    assign blank    = emb ? (st_q.eh | st_q.ev) : (hs_act | vs_act);
    assign vblank   = emb ? st_q.ev : vs_act;
    assign cur_mode = st_q.mode;

    pxd_timecode u_tc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (emb),
        .byte_i  (byte_w),
        .strip_o (strip),
        .flag_o  (flag)
    );

    pxd_rgb_unpack u_rgb (
        .mode_i   (st_q.mode),
        .first_i  (st_q.first),
        .second_i (din_i),
        .pix_o    (rgb_pix)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (flag) begin
            st_d.ef = byte_w[FLG_F];
            st_d.ev = byte_w[FLG_V];
            st_d.eh = byte_w[FLG_H];
        end
        if (vblank)
            st_d.mode = fmt_decode(fmt_i);
        if (blank) begin
            st_d.phase = '0;
        end else if (!strip) begin
            if (!ycc_m) begin
                if (st_q.phase == 2'd0) begin
                    st_d.first = din_i;
                    st_d.phase = 2'd1;
                end else begin
                    st_d.pix   = rgb_pix;
                    st_d.valid = 1'b1;
                    st_d.phase = 2'd0;
                end
            end else begin
                st_d.phase = st_q.phase + 2'd1;
                case (st_q.phase)
                    2'd0: st_d.cb = byte_w;
                    2'd1: st_d.y0 = byte_w;
                    2'd2: begin
                        st_d.cr    = byte_w;
                        st_d.pix   = '{c0: st_q.y0, c1: st_q.cb, c2: byte_w};
                        st_d.valid = 1'b1;
                    end
                    default: begin
                        st_d.pix   = '{c0: byte_w, c1: st_q.cb, c2: st_q.cr};
                        st_d.valid = 1'b1;
                    end
                endcase
            end
        end
        st_d.ycc = ycc_m;
        st_d.hs  = emb ? st_d.eh : hs_act;
        st_d.vs  = emb ? st_d.ev : vs_act;
        st_d.fld = emb ? st_d.ef : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign pix_valid_o = st_q.valid;
    assign c0_o        = st_q.pix.c0;
    assign c1_o        = st_q.pix.c1;
    assign c2_o        = st_q.pix.c2;
    assign ycc_o       = st_q.ycc;
    assign hs_o        = st_q.hs;
    assign vs_o        = st_q.vs;
    assign field_o     = st_q.fld;
endmodule

// File: rtl/pxd_deinterleave_chk.sv
module pxd_deinterleave_chk
    import pxd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [BUS_W-1:0] din_i,
    input logic             hs_i,
    input logic             hpol_i,
    input logic [FMT_W-1:0] cur_mode,
    input logic             vblank,
    input logic             pix_valid_o,
    input logic             ycc_o,
    input logic [CH_W-1:0]  c1_o,
    input logic [CH_W-1:0]  c2_o,
    input logic             hs_o
);
    // R5
    rgb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && !ycc_o) |=> !pix_valid_o);

    // R6
    hs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != FMT_YCC_EMB && hs_i == hpol_i) |=> hs_o);

    // R6
    hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != FMT_YCC_EMB && hs_i != hpol_i) |=> !hs_o);

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(cur_mode)) |-> $past(vblank));

    // R8
    chroma_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pix_valid_o && ycc_o && $past(pix_valid_o))
        |-> ($stable(c1_o) && $stable(c2_o)));

    // R10
    lead_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == FMT_YCC_EMB && din_i[CH_W-1:0] == CODE_LEAD) |=> !pix_valid_o);
endmodule

bind pxd_deinterleave pxd_deinterleave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .din_i       (din_i),
    .hs_i        (hs_i),
    .hpol_i      (hpol_i),
    .cur_mode    (cur_mode),
    .vblank      (vblank),
    .pix_valid_o (pix_valid_o),
    .ycc_o       (ycc_o),
    .c1_o        (c1_o),
    .c2_o        (c2_o),
    .hs_o        (hs_o)
);

// File: tb/pxd_deinterleave_test.sv
module pxd_deinterleave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] din = '0;
    logic        hs = 1'b0, vs = 1'b0, hpol = 1'b1, vpol = 1'b1;
    logic [2:0]  fmt = 3'd0;
    logic        pv, ycc, hso, vso, fld;
    logic [7:0]  c0, c1, c2;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pxd_deinterleave uut (
        .clk(clk), .rst_n(rst_n), .din_i(din), .hs_i(hs), .vs_i(vs),
        .hpol_i(hpol), .vpol_i(vpol), .fmt_i(fmt), .pix_valid_o(pv),
        .c0_o(c0), .c1_o(c1), .c2_o(c2), .ycc_o(ycc), .hs_o(hso),
        .vs_o(vso), .field_o(fld)
    );

    typedef struct packed {
        logic [2:0]  f;
        logic        h;
        logic        v;
        logic [11:0] d;
        logic        ev;
        logic [7:0]  r;
        logic [7:0]  g;
        logic [7:0]  b;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b0, 1'b1, 12'h000, 1'b0, 8'h00, 8'h00, 8'h00},
        '{3'd0, 1'b1, 1'b0, 12'h000, 1'b0, 8'h00, 8'h00, 8'h00},
        '{3'd0, 1'b0, 1'b0, 12'h0A5, 1'b0, 8'h00, 8'h00, 8'h00},
        '{3'd0, 1'b0, 1'b0, 12'h0C3, 1'b1, 8'hC0, 8'h74, 8'h28},
        '{3'd2, 1'b0, 1'b1, 12'h000, 1'b0, 8'h00, 8'h00, 8'h00},
        '{3'd2, 1'b0, 1'b0, 12'h5BC, 1'b0, 8'h00, 8'h00, 8'h00},
        '{3'd2, 1'b0, 1'b0, 12'hE7A, 1'b1, 8'hE7, 8'hA5, 8'hBC},
        '{3'd0, 1'b0, 1'b0, 12'h123, 1'b0, 8'h00, 8'h00, 8'h00},
        '{3'd0, 1'b0, 1'b0, 12'h456, 1'b1, 8'h45, 8'h61, 8'h23},
        '{3'd1, 1'b0, 1'b1, 12'h000, 1'b0, 8'h00, 8'h00, 8'h00},
        '{3'd1, 1'b0, 1'b0, 12'h0FF, 1'b0, 8'h00, 8'h00, 8'h00},
        '{3'd1, 1'b0, 1'b0, 12'h0AA, 1'b1, 8'h50, 8'hB8, 8'hF8}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [11:0] d, input logic h, input logic v);
        @(negedge clk);
        din = d; hs = h; vs = v;
        @(posedge clk);
        #1;
    endtask

    task automatic pix(input string req, input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2);
        chk(req, {31'd0, pv}, 32'd1);
        chk(req, {8'd0, c0, c1, c2}, {8'd0, e0, e1, e2});
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 valid in reset", {31'd0, pv}, 0);
        chk("R1 syncs in reset", {28'd0, hso, vso, fld, ycc}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 after release", {28'd0, pv, hso, vso, ycc}, 0);

        // R2 R3 R4 R7: table walk
        for (int i = 0; i < NV; i++) begin
            fmt = VEC[i].f;
            step(VEC[i].d, VEC[i].h, VEC[i].v);
            chk($sformatf("R2/R3/R4/R7 vec %0d valid", i), {31'd0, pv}, {31'd0, VEC[i].ev});
            if (VEC[i].ev)
                chk($sformatf("R2/R3/R4/R7 vec %0d pixel", i), {8'd0, c0, c1, c2},
                    {8'd0, VEC[i].r, VEC[i].g, VEC[i].b});
        end

        // R5: hsync splits a pair, pairing restarts
        step(12'h0FF, 1'b0, 1'b0);
        chk("R5 first half", {31'd0, pv}, 0);
        step(12'h000, 1'b1, 1'b0);
        chk("R5 in blank", {31'd0, pv}, 0);
        step(12'h0FF, 1'b0, 1'b0);
        chk("R5 restart first half", {31'd0, pv}, 0);
        step(12'h0AA, 1'b0, 1'b0);
        pix("R5 restarted pair", 8'h50, 8'hB8, 8'hF8);
        step(12'h0FF, 1'b0, 1'b0);
        chk("R5 one cycle strobe", {31'd0, pv}, 0);

        // R6: polarity
        hpol = 1'b0;
        step(12'h000, 1'b0, 1'b0);
        chk("R6 low-active hs", {30'd0, hso, pv}, 32'd2);
        step(12'h000, 1'b1, 1'b0);
        chk("R6 low-active hs idle", {31'd0, hso}, 0);
        vpol = 1'b0;
        step(12'h000, 1'b1, 1'b0);
        chk("R6 low-active vs", {30'd0, vso, pv}, 32'd2);
        hpol = 1'b1; vpol = 1'b1;

        // R8: byte-serial with sync pins
        fmt = 3'd3;
        step(12'h000, 1'b0, 1'b1);
        step(12'h040, 1'b0, 1'b0);
        chk("R8 after Cb", {31'd0, pv}, 0);
        step(12'h051, 1'b0, 1'b0);
        chk("R8 after Y0", {31'd0, pv}, 0);
        step(12'h062, 1'b0, 1'b0);
        pix("R8 pixel 0", 8'h51, 8'h40, 8'h62);
        chk("R8 ycc flag", {30'd0, ycc, fld}, 32'd2);
        step(12'h073, 1'b0, 1'b0);
        pix("R8 pixel 1", 8'h73, 8'h40, 8'h62);
        step(12'h011, 1'b0, 1'b0);
        chk("R8 next Cb", {31'd0, pv}, 0);

        // R9 R10: embedded codes, hs pin held active throughout
        fmt = 3'd4;
        step(12'h000, 1'b0, 1'b1);
        step(12'h0FF, 1'b1, 1'b0);
        chk("R10 lead stripped", {31'd0, pv}, 0);
        step(12'h000, 1'b1, 1'b0);
        step(12'h000, 1'b1, 1'b0);
        step(12'h0D0, 1'b1, 1'b0);
        chk("R9 blank code flags", {28'd0, pv, hso, vso, fld}, 32'h5);
        step(12'h0FF, 1'b1, 1'b0);
        chk("R10 lead stripped 2", {31'd0, pv}, 0);
        step(12'h000, 1'b1, 1'b0);
        step(12'h000, 1'b1, 1'b0);
        step(12'h0C0, 1'b1, 1'b0);
        chk("R9 active code flags", {28'd0, pv, hso, vso, fld}, 32'h1);
        step(12'h010, 1'b1, 1'b0);
        step(12'h020, 1'b1, 1'b0);
        chk("R9 pins ignored", {30'd0, pv, hso}, 0);
        step(12'h030, 1'b1, 1'b0);
        pix("R9 pixel 0", 8'h20, 8'h10, 8'h30);
        step(12'h040, 1'b1, 1'b0);
        pix("R9 pixel 1", 8'h40, 8'h10, 8'h30);
        step(12'h0FF, 1'b1, 1'b0);
        chk("R10 lead in active", {31'd0, pv}, 0);
        step(12'h000, 1'b1, 1'b0);
        chk("R10 zero stripped", {31'd0, pv}, 0);
        step(12'h000, 1'b1, 1'b0);
        chk("R10 zero stripped 2", {31'd0, pv}, 0);
        step(12'h0F0, 1'b1, 1'b0);
        chk("R9 vblank code", {28'd0, pv, hso, vso, fld}, 32'h7);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule